// File: doc/BRIEF.md
# Edge-Tracking Bit Clock Recovery

This block sits after a tone discriminator that delivers one mark/space decision per audio sample. It recovers the bit timing from that stream with a phase accumulator that advances by a fixed amount on every accepted sample. Whenever two consecutive decisions disagree, the accumulator is pulled toward the transition. If the phase lies in the lower half of its range it is pushed forward by a small step. Otherwise it is pulled back by the same step.

Each time the accumulator crosses its maximum, the block declares a bit instant. It then emits a recovered data bit, taken as the 2-of-3 majority of the three newest decisions. The same bit is appended to a running register of recovered bits. Samples arrive with a valid strobe, and cycles without the strobe leave all state untouched. Downstream line decoding and framing are handled elsewhere.

Top module: `bitclk_recover`

## Requirements
- R1: On every cycle with `dec_valid` high, `dec_bit` is shifted into a decision history register at bit 0, and older decisions move one place toward the MSB.
- R2: On a valid sample whose `dec_bit` differs from the previous decision (history bit 0), the phase is first raised by `PH_STEP` if it is below `PH_THRESH` (default 128).
- R3: Under the same edge condition, if the phase is at or above `PH_THRESH`, it is first lowered by `PH_STEP` (default 8).
- R4: After any edge adjustment, each valid sample adds `PH_INC` (default 32) to the phase. Cycles with `dec_valid` low change neither the phase, the history nor the recovered-bit register.
- R5: When the adjusted and incremented phase is greater than or equal to `PH_MAX` (default 256), `PH_MAX` is subtracted and a bit instant occurs. The phase always stays below `PH_MAX`.
- R6: The bit emitted at a bit instant is 1 exactly when at least two of the three newest history bits are 1. These three bits include the decision that caused the instant, so the patterns 111, 110, 101 and 011 give 1.
- R7: At each bit instant the emitted bit is shifted into `found_bits` at bit 0, and older bits move toward the MSB.
- R8: `bit_strobe` is high for exactly one cycle per bit instant, in the cycle after the valid sample that caused it, with `bit_data` holding the bit. It is never high unless the previous cycle carried a valid sample.
- R9: While `rst_n` is low, the phase, the history, `found_bits`, `bit_strobe` and `bit_data` are all cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | A new decision is present this cycle |
| dec_bit | input | 1 | Mark (1) / space (0) decision |
| bit_strobe | output | 1 | One-cycle pulse at each recovered bit |
| bit_data | output | 1 | Recovered bit, valid with `bit_strobe` |
| found_bits | output | FOUND_W | Recovered bits, newest in bit 0 |

## Verification
The assertions assume that `dec_valid` and `dec_bit` are settled at each rising edge. They also assume the parameters satisfy `PH_INC + PH_STEP <= PH_MAX` and `PH_STEP <= PH_THRESH`, so that one subtraction of `PH_MAX` always brings the phase back into range. The stimulus changes inputs only on falling edges and keeps the default parameters. It sweeps every 8-bit pattern with bit lengths of 7, 8 and 9 samples, so the phase meets the threshold from both sides. Idle cycles are scattered through the stream to show that unstrobed cycles have no effect.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  // 2-of-3 majority over the three newest decisions
  function automatic logic maj3(input logic [2:0] h);
    return (h[0] & h[1]) | (h[0] & h[2]) | (h[1] & h[2]);
  endfunction
endpackage

// File: rtl/bcr_history.sv
module bcr_history #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_q,
  output logic [HIST_W-1:0] hist_next,
  output logic              edge_now
);
  always_comb begin
    hist_next = {hist_q[HIST_W-2:0], bit_in};
    edge_now  = valid & (hist_q[0] ^ bit_in);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     hist_q <= '0;
    else if (valid) hist_q <= hist_next;
  end
endmodule

// File: rtl/bcr_phase.sv
module bcr_phase #(
  parameter int PH_MAX    = 256,
  parameter int PH_INC    = 32,
  parameter int PH_THRESH = 128,
  parameter int PH_STEP   = 8,
  parameter int PH_W      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid,
  input  logic            edge_now,
  output logic [PH_W-1:0] phase_q,
  output logic            wrap
);
  localparam logic [PH_W-1:0] K_MAX  = PH_W'(PH_MAX);
  localparam logic [PH_W-1:0] K_INC  = PH_W'(PH_INC);
  localparam logic [PH_W-1:0] K_THR  = PH_W'(PH_THRESH);
  localparam logic [PH_W-1:0] K_STEP = PH_W'(PH_STEP);

  // edge nudge: advance below threshold, retard at or above it
  function automatic logic [PH_W-1:0] nudge(input logic [PH_W-1:0] p, input logic e);
    if (!e)        return p;
    if (p < K_THR) return p + K_STEP;
    return p - K_STEP;
  endfunction

  logic [PH_W-1:0] sum;

  always_comb begin
    sum  = nudge(phase_q, edge_now) + K_INC;
    wrap = valid && (sum >= K_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     phase_q <= '0;
    else if (wrap)  phase_q <= sum - K_MAX;
    else if (valid) phase_q <= sum;
  end
endmodule

// File: rtl/bcr_collect.sv
module bcr_collect #(
  parameter int FOUND_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wrap,
  input  logic               vote,
  output logic               strobe_q,
  output logic               data_q,
  output logic [FOUND_W-1:0] found_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      data_q   <= 1'b0;
      found_q  <= '0;
    end else begin
      strobe_q <= wrap;
      if (wrap) begin
        data_q  <= vote;
        found_q <= {found_q[FOUND_W-2:0], vote};
      end
    end
  end
endmodule

// File: rtl/bitclk_recover.sv
module bitclk_recover #(
  parameter int PH_MAX    = 256,
  parameter int PH_INC    = 32,
  parameter int PH_THRESH = PH_MAX / 2,
  parameter int PH_STEP   = 8,
  parameter int HIST_W    = 8,
  parameter int FOUND_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dec_valid,
  input  logic               dec_bit,
  output logic               bit_strobe,
  output logic               bit_data,
  output logic [FOUND_W-1:0] found_bits
);
  localparam int PH_W = $clog2(PH_MAX) + 2;

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_next;
  logic              edge_now;
  logic [PH_W-1:0]   phase_q;
  logic              wrap;
  logic              vote;

  bcr_history #(.HIST_W(HIST_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .valid(dec_valid), .bit_in(dec_bit),
    .hist_q(hist_q), .hist_next(hist_next), .edge_now(edge_now)
  );

  bcr_phase #(
    .PH_MAX(PH_MAX), .PH_INC(PH_INC), .PH_THRESH(PH_THRESH),
    .PH_STEP(PH_STEP), .PH_W(PH_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .valid(dec_valid), .edge_now(edge_now),
    .phase_q(phase_q), .wrap(wrap)
  );

  assign vote = bcr_pkg::maj3(hist_next[2:0]);

  bcr_collect #(.FOUND_W(FOUND_W)) u_coll (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .vote(vote),
    .strobe_q(bit_strobe), .data_q(bit_data), .found_q(found_bits)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int PH_MAX  = 256,
  parameter int PH_W    = 10,
  parameter int HIST_W  = 8,
  parameter int FOUND_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               dec_valid,
  input logic               dec_bit,
  input logic               bit_strobe,
  input logic               bit_data,
  input logic [FOUND_W-1:0] found_bits,
  input logic [PH_W-1:0]    phase_q,
  input logic [HIST_W-1:0]  hist_q
);
  assert_hist_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> hist_q[0] == $past(dec_bit));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |=> ($stable(phase_q) && $stable(hist_q) && $stable(found_bits)));

  assert_phase_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q < PH_W'(PH_MAX));

  assert_vote_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> bit_data == bcr_pkg::maj3(hist_q[2:0]));

  assert_found_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> (found_bits[0] == bit_data &&
                    found_bits[FOUND_W-1:1] == $past(found_bits[FOUND_W-2:0])));

  assert_strobe_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_strobe |-> $past(dec_valid));
endmodule

bind bitclk_recover bcr_checker #(
  .PH_MAX(PH_MAX), .PH_W(PH_W), .HIST_W(HIST_W), .FOUND_W(FOUND_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_bit(dec_bit),
  .bit_strobe(bit_strobe), .bit_data(bit_data), .found_bits(found_bits),
  .phase_q(phase_q), .hist_q(hist_q)
);

// File: tb/test_bitclk_recover.sv
module test_bitclk_recover;
  localparam int CLK_PERIOD = 10;
  localparam int MAXP = 256, INC = 32, THR = 128, STEP = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dec_valid = 1'b0;
  logic dec_bit = 1'b0;
  logic bit_strobe, bit_data;
  logic [7:0] found_bits;

  int checks = 0, failures = 0;
  int m_phase = 0;
  logic [7:0] m_hist = '0;
  logic [7:0] m_found = '0;
  logic m_strobe = 1'b0, m_data = 1'b0;
  bit done = 1'b0;

  bitclk_recover i_bitclk_recover (
    .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_bit(dec_bit),
    .bit_strobe(bit_strobe), .bit_data(bit_data), .found_bits(found_bits)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, compare at the following negedge
  task automatic step(input logic v, input logic b);
    int p;
    int ones;
    dec_valid = v;
    dec_bit   = b;
    m_strobe  = 1'b0;
    if (v) begin
      p = m_phase;
      if (m_hist[0] != b) p = (p < THR) ? p + STEP : p - STEP;   // R2 R3
      p = p + INC;                                               // R4
      m_hist = {m_hist[6:0], b};                                 // R1
      if (p >= MAXP) begin                                       // R5
        p = p - MAXP;
        ones = int'(m_hist[0]) + int'(m_hist[1]) + int'(m_hist[2]);
        m_data = (ones >= 2);                                    // R6
        m_found = {m_found[6:0], m_data};                        // R7
        m_strobe = 1'b1;
      end
      m_phase = p;
    end
    @(negedge clk);
    chk(bit_strobe == m_strobe, "R8 strobe timing (R2 R3 R4 R5)", int'(bit_strobe), int'(m_strobe));
    if (m_strobe) begin
      chk(bit_data == m_data, "R6 majority bit", int'(bit_data), int'(m_data));
      chk(found_bits == m_found, "R7 found_bits", int'(found_bits), int'(m_found));
    end else if (!v) begin
      chk(found_bits == m_found, "R4 idle cycle left found_bits", int'(found_bits), int'(m_found));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bit_strobe == 1'b0, "R9 reset strobe", int'(bit_strobe), 0);
    chk(bit_data == 1'b0, "R9 reset data", int'(bit_data), 0);
    chk(found_bits == 8'h00, "R9 reset found_bits", int'(found_bits), 0);
    rst_n = 1'b1;
    // idle first: nothing may move (R4)
    for (int i = 0; i < 4; i++) step(1'b0, 1'b1);
    for (int pat = 0; pat < 256; pat++) begin
      for (int i = 0; i < 8; i++) begin
        int len = 7 + ((pat + i) % 3);
        for (int s = 0; s < len; s++) begin
          // occasional single-sample glitch to exercise the vote
          logic b = pat[7-i] ^ (((pat + s) % 11 == 0) && s > 1 && s < len - 2);
          step(1'b1, b);
          if ((pat + i + s) % 13 == 0) step(1'b0, ~b);
        end
      end
    end
    // second reset in the middle of activity (R9)
    rst_n = 1'b0;
    dec_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(found_bits == 8'h00, "R9 mid-run reset found_bits", int'(found_bits), 0);
    chk(bit_strobe == 1'b0, "R9 mid-run reset strobe", int'(bit_strobe), 0);
    rst_n = 1'b1;
    m_phase = 0; m_hist = '0; m_found = '0;
    // from cleared phase, a steady 1 stream: first edge advances (R2)
    for (int s = 0; s < 40; s++) step(1'b1, 1'b1);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule